// File: doc/BRIEF.md
# Set/Clear GPIO Register Bank

A general-purpose I/O port of 32 pins, reached through a small valid/ready register port. Each pin has an output data latch and a drive-enable latch. Software never rewrites these latches whole. It writes a mask to a set register or to a clear register, and only the pins whose mask bit is 1 change. Several agents can therefore share the port without a read-modify-write race.

A separate read-only register returns the level seen on every pin. A driven pin reads back its own output value. An undriven pin reads the external level. Both pass through a two-flop synchronizer before they reach the read path.

The register window is 256 bytes. Data words are 32 bits, and bit n of a word is pin n (little-endian). Address bits [1:0] are ignored.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset, pad_o and pad_oe_o are all 0, so every pin is undriven. A read of offset 0x40 then returns the external pad_i levels.
- R2: A write to offset 0x00 sets to 1 the output bit of each pin whose data bit is 1. All other output bits keep their value.
- R3: A write to offset 0x10 clears to 0 the output bit of each pin whose data bit is 1. All other output bits keep their value.
- R4: A write to offset 0x20 turns on the driver (pad_oe_o bit = 1) of each pin whose data bit is 1. Other drivers are unchanged.
- R5: A write to offset 0x30 turns off the driver of each pin whose data bit is 1, leaving that pin as an input. Other drivers are unchanged.
- R6: A read of offset 0x40 returns one bit per pin, bit n = pin n. The bit is pad_o[n] when pin n is driven and pad_i[n] when it is not.
- R7: A pin level change is present before clock edge E. A read accepted at edge E or E+1 returns the old level. A read accepted at edge E+2 returns the new level.
- R8: Reads of offsets 0x00, 0x10, 0x20, 0x30 and of any unmapped offset return 0. Writes to 0x40 or to an unmapped offset change neither pad_o nor pad_oe_o.
- R9: req_ready_o is 1 whenever reset is released. rsp_valid_o is 1 in the cycle after an accepted read and 0 in the cycle after an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access request |
| req_ready_o | output | 1 | Port can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset inside the window |
| req_wdata_i | input | 32 | Write mask, bit n = pin n |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| pad_i | input | 32 | External pin levels |
| pad_o | output | 32 | Output data latch |
| pad_oe_o | output | 32 | Driver enable per pin |

## Verification
A write takes effect at the edge that accepts it, so pad_o and pad_oe_o are checked at the falling edge that follows. Read data is registered, so it is sampled at the falling edge one cycle after the request. The input path adds two synchronizer stages. For that reason the bench issues back-to-back reads right after changing pad_i and expects old, old, then new data. Inputs are driven on falling edges, so no check depends on the order of processes at a rising edge.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;

  localparam logic [ADDR_W-1:0] OFF_OUT_SET = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_OUT_CLR = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_OE_SET  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_OE_CLR  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_LEVEL   = 8'h40;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OUT_SET,
    SEL_OUT_CLR,
    SEL_OE_SET,
    SEL_OE_CLR,
    SEL_LEVEL
  } reg_sel_e;
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  output logic          out_set_o,
  output logic          out_clr_o,
  output logic          oe_set_o,
  output logic          oe_clr_o,
  output logic          level_rd_o
);
  localparam int unsigned WIDX_W = AW - 2;

  reg_sel_e sel;
  logic [WIDX_W-1:0] widx;

  assign widx = addr_i[AW-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (widx == OFF_OUT_SET[AW-1:2])      sel = SEL_OUT_SET;
    else if (widx == OFF_OUT_CLR[AW-1:2]) sel = SEL_OUT_CLR;
    else if (widx == OFF_OE_SET[AW-1:2])  sel = SEL_OE_SET;
    else if (widx == OFF_OE_CLR[AW-1:2])  sel = SEL_OE_CLR;
    else if (widx == OFF_LEVEL[AW-1:2])   sel = SEL_LEVEL;
  end

  assign out_set_o  = acc_i &  write_i & (sel == SEL_OUT_SET);
  assign out_clr_o  = acc_i &  write_i & (sel == SEL_OUT_CLR);
  assign oe_set_o   = acc_i &  write_i & (sel == SEL_OE_SET);
  assign oe_clr_o   = acc_i &  write_i & (sel == SEL_OE_CLR);
  assign level_rd_o = acc_i & ~write_i & (sel == SEL_LEVEL);

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({out_set_o, out_clr_o, oe_set_o, oe_clr_o, level_rd_o})) // R8
    else $error("more than one register strobe");
endmodule

// File: rtl/gpio_sc_latch.sv
module gpio_sc_latch #(
  parameter int unsigned       W   = 32,
  parameter logic [W-1:0]      RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  // clear has priority when both masks hit a bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST;
    else         q_q <= (q_q | set_i) & ~clr_i;
  end

  assign q_o = q_q;

  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(set_i & ~clr_i) |=> ((q_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i))) // R2 R4
    else $error("set bit not applied");

  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |clr_i |=> ((q_o & $past(clr_i)) == '0)) // R3 R5
    else $error("clear bit not applied");

  AST_UNTOUCHED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((q_o ^ $past(q_o)) & ~$past(set_i | clr_i)) == '0)) // R8
    else $error("unmasked bit changed");
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned N      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] out_i,
  input  logic [N-1:0] oe_i,
  input  logic [N-1:0] ext_i,
  output logic [N-1:0] level_o
);
  logic [N-1:0] pin_lvl;

  for (genvar p = 0; p < N; p++) begin : g_pin
    logic [STAGES-1:0] sync_q;

    // pad model: a driven pin shows its own output
    assign pin_lvl[p] = oe_i[p] ? out_i[p] : ext_i[p];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[STAGES-2:0], pin_lvl[p]};
    end

    assign level_o[p] = sync_q[STAGES-1];
  end
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned N_PINS = DATA_W,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [N_PINS-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [N_PINS-1:0] rsp_rdata_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe_o
);
  logic acc;
  logic out_set, out_clr, oe_set, oe_clr, level_rd;
  logic [N_PINS-1:0] level;
  logic rsp_valid_q;
  logic [N_PINS-1:0] rdata_q;

  assign req_ready_o = rst_ni;
  assign acc         = req_valid_i & req_ready_o;

  gpio_reg_decode #(.AW(AW)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .write_i   (req_write_i),
    .addr_i    (req_addr_i),
    .out_set_o (out_set),
    .out_clr_o (out_clr),
    .oe_set_o  (oe_set),
    .oe_clr_o  (oe_clr),
    .level_rd_o(level_rd)
  );

  gpio_sc_latch #(.W(N_PINS), .RST('0)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (out_set ? req_wdata_i : '0),
    .clr_i (out_clr ? req_wdata_i : '0),
    .q_o   (pad_o)
  );

  gpio_sc_latch #(.W(N_PINS), .RST('0)) u_oe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (oe_set ? req_wdata_i : '0),
    .clr_i (oe_clr ? req_wdata_i : '0),
    .q_o   (pad_oe_o)
  );

  gpio_pad_sync #(.N(N_PINS), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .out_i  (pad_o),
    .oe_i   (pad_oe_o),
    .ext_i  (pad_i),
    .level_o(level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= acc & ~req_write_i;
      if (acc & ~req_write_i) rdata_q <= level_rd ? level : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;

  AST_RSP_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o) // R9
    else $error("no response after read");

  AST_NO_RSP_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> !rsp_valid_o) // R9
    else $error("response after write");

  AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i && !req_write_i)) // R9
    else $error("spurious response");
endmodule

// File: tb/gpio_setclr_bank_tb.sv
module gpio_setclr_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  gpio_setclr_bank u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_valid_i(req_valid),
    .req_ready_o(req_ready),
    .req_write_i(req_write),
    .req_addr_i (req_addr),
    .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata),
    .pad_i      (pad_in),
    .pad_o      (pad_out),
    .pad_oe_o   (pad_oe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R9 no rsp after write", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 rsp after read", {31'b0, rsp_valid}, 32'h1);
    d = rsp_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 pad_o reset", pad_out, 32'h0);
    check("R1 pad_oe reset", pad_oe, 32'h0);
    check("R9 ready", {31'b0, req_ready}, 32'h1);
    check("R9 idle rsp", {31'b0, rsp_valid}, 32'h0);
    pad_in = 32'hC3A5_0F96;
    repeat (3) @(negedge clk);
    bus_rd(8'h40, d);
    check("R1 undriven read", d, 32'hC3A5_0F96);
  endtask

  task automatic t_out_setclr();
    bus_wr(8'h00, 32'h0000_00F0);
    check("R2 set", pad_out, 32'h0000_00F0);
    bus_wr(8'h00, 32'h8000_0001);
    check("R2 set keeps others", pad_out, 32'h8000_00F1);
    bus_wr(8'h10, 32'h0000_0030);
    check("R3 clear", pad_out, 32'h8000_00C1);
    bus_wr(8'h10, 32'h0000_0000);
    check("R3 zero mask", pad_out, 32'h8000_00C1);
    check("R2 oe untouched", pad_oe, 32'h0);
  endtask

  task automatic t_oe_setclr();
    bus_wr(8'h20, 32'hFFFF_0000);
    check("R4 oe set", pad_oe, 32'hFFFF_0000);
    bus_wr(8'h20, 32'h0000_0003);
    check("R4 oe set keeps others", pad_oe, 32'hFFFF_0003);
    bus_wr(8'h30, 32'h0F00_0002);
    check("R5 tristate", pad_oe, 32'hF0FF_0001);
    check("R5 data untouched", pad_out, 32'h8000_00C1);
  endtask

  task automatic t_level_mix();
    logic [31:0] d, exp;
    repeat (3) @(negedge clk);
    exp = (pad_out & pad_oe) | (pad_in & ~pad_oe);
    bus_rd(8'h40, d);
    check("R6 mixed level", d, exp);
  endtask

  task automatic t_sync_lag();
    logic [31:0] d0, d1, d2;
    bus_wr(8'h30, 32'hFFFF_FFFF);
    pad_in = 32'h1111_1111;
    repeat (3) @(negedge clk);
    pad_in = 32'hEEEE_EEEE;
    bus_rd(8'h40, d0);
    bus_rd(8'h40, d1);
    bus_rd(8'h40, d2);
    check("R7 edge E old", d0, 32'h1111_1111);
    check("R7 edge E+1 old", d1, 32'h1111_1111);
    check("R7 edge E+2 new", d2, 32'hEEEE_EEEE);
  endtask

  task automatic t_unmapped();
    logic [31:0] d, po, oe;
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_rd(8'h00, d); check("R8 read 0x00", d, 32'h0);
    bus_rd(8'h10, d); check("R8 read 0x10", d, 32'h0);
    bus_rd(8'h20, d); check("R8 read 0x20", d, 32'h0);
    bus_rd(8'h30, d); check("R8 read 0x30", d, 32'h0);
    bus_rd(8'hFC, d); check("R8 read unmapped", d, 32'h0);
    bus_wr(8'h10, 32'h5555_5555);
    bus_wr(8'h30, 32'h0000_FFFF);
    po = pad_out; oe = pad_oe;
    bus_wr(8'h40, 32'hFFFF_FFFF);
    bus_wr(8'h84, 32'hFFFF_FFFF);
    check("R8 write 0x40 pad_o", pad_out, po);
    check("R8 write 0x40 pad_oe", pad_oe, oe);
    bus_wr(8'h44, 32'h0);
    check("R8 unmapped pad_o", pad_out, 32'hAAAA_AAAA);
    check("R8 unmapped pad_oe", pad_oe, 32'hFFFF_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_out_setclr();
    t_oe_setclr();
    t_level_mix();
    t_sync_lag();
    t_unmapped();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule